// File: doc/BRIEF.md
# Pulse Peak Search and Primitive Builder

This block follows one filtered trigger waveform together with a word of eight threshold flags. Once per completed input packet the caller raises a strobe while it presents the packet's waveform sample, its flag word and the running 32-bit timestamp. The block derives a search-window bit from the flags and a map of 2-bit selectors. The window is open for as long as at least one flag whose selector names this block's index is set. While the window is open, the block keeps the largest sample and the time it arrived. It also keeps the flag word seen at that peak and a running OR of every flag word seen in the window.

When the window closes, the block forms one 64-bit primitive and presents it on a valid-qualified stream. The primitive is held back by a number of clock cycles equal to the block's index, so that several copies with different indices never drive a shared output in the same cycle. A window that lasted longer than a configured limit is taken to be a saturated pulse. For such a pulse the reported time is the window start time plus a configured offset, in place of the time of the peak. The limit and the offset are 16-bit values that are loaded through a write strobe.

Top module: `peak_prim_builder`

## Requirements
- R1: The window bit is the OR over the eight flags of (flag i set AND selector i equals INDEX). Selector i occupies bits [2i+1:2i] of `sel_map`. Flags whose selector holds another value have no effect on the window.
- R2: State changes only on cycles with `pkt_strobe` high. Changes on sample, flags or timestamp between strobes are ignored.
- R3: A strobe with the window bit set while no window is open opens one. The peak amplitude takes the sample. The peak time and the start time take `now_ts`. The at-peak and during-window words both take the flags.
- R4: Each strobe inside an open window replaces the peak amplitude, peak time and at-peak word only when the sample is strictly greater than the stored peak, compared as unsigned 16-bit values. A tie keeps the earlier peak.
- R5: Each strobe inside an open window ORs its flags into the during-window word. The strobe that closes the window contributes neither its sample nor its flags.
- R6: A primitive is laid out as peak time [63:32], peak amplitude [31:16], at-peak flags [15:8] and during-window flags [7:0].
- R7: When the window closes, the block computes (now_ts − start time) modulo 2^32. If this is greater than the limit, the reported time is start time + offset, modulo 2^32. If it is equal to the limit or less, the recorded peak time is reported.
- R8: `prim_valid` rises exactly INDEX+1 clock edges after the closing strobe is sampled and stays high for one cycle. `prim_chan` always equals INDEX.
- R9: Reset clears the window state, drops `prim_valid`, and sets both the limit and the offset to zero.
- R10: A cycle with `cfg_we` high loads the limit from `cfg_max_len` and the offset from `cfg_sat_ofs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Loads the window-length limit and the saturation offset |
| cfg_max_len | input | 16 | Window-length limit in timestamp ticks |
| cfg_sat_ofs | input | 16 | Offset added to the start time for saturated pulses |
| sel_map | input | 16 | Eight 2-bit selectors, selector i at [2i+1:2i] |
| pkt_strobe | input | 1 | One cycle per completed input packet |
| pkt_sample | input | 16 | Waveform sample of the packet |
| pkt_flags | input | 8 | Threshold flags of the packet |
| now_ts | input | 32 | Running timestamp |
| prim_valid | output | 1 | Primitive present this cycle |
| prim_chan | output | 2 | Index of this block |
| prim_data | output | 64 | Primitive: time, amplitude, at-peak and during-window flags |

## Verification
On every cycle the assertions check the following: the peak never shrinks inside a window, a tie leaves the peak time alone, the during-window word only gains bits, a window opens with the start time equal to the peak time, and nothing moves without a strobe. They also check that `prim_valid` is a single-cycle pulse and that a short window reports the recorded peak time. Some properties can only be shown by the bench scenarios. These are the full selector decode for every flag and selector value, the exact output delay, and the primitive contents over long sequences. Others are the saturation boundary at a difference equal to the limit, the rollover of the timestamp, and the zeroed configuration after reset.

// File: rtl/ps_pkg.sv
package ps_pkg;
   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_OPEN  = 2'd1,
      ACT_HOLD  = 2'd2,
      ACT_CLOSE = 2'd3
   } win_act_t;

   function automatic win_act_t classify(input logic win_now, input logic win_was);
      if (!win_was && win_now)      return ACT_OPEN;
      else if (win_was && win_now)  return ACT_HOLD;
      else if (win_was && !win_now) return ACT_CLOSE;
      else                          return ACT_IDLE;
   endfunction
endpackage

// File: rtl/ps_window_gate.sv
module ps_window_gate #(
   parameter int FLAG_N = 8,
   parameter int SEL_W  = 2,
   parameter int INDEX  = 0
) (
   input  logic [FLAG_N-1:0]       flags,
   input  logic [FLAG_N*SEL_W-1:0] sel_map,
   output logic                    win
);
   localparam logic [SEL_W-1:0] IDX = SEL_W'(INDEX);
   logic [FLAG_N-1:0] hit;

   generate
      for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
         assign hit[g] = flags[g] && (sel_map[g*SEL_W +: SEL_W] == IDX);
      end
   endgenerate

   assign win = |hit;
endmodule

// File: rtl/ps_peak_tracker.sv
module ps_peak_tracker #(
   parameter int SAMPLE_W = 16,
   parameter int FLAG_N   = 8,
   parameter int TS_W     = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                strobe,
   input  logic                win,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [FLAG_N-1:0]   flags,
   input  logic [TS_W-1:0]     now_ts,
   output logic                in_win,
   output logic                close_evt,
   output logic [SAMPLE_W-1:0] pk_amp,
   output logic [TS_W-1:0]     pk_time,
   output logic [TS_W-1:0]     t_start,
   output logic [FLAG_N-1:0]   w_peak,
   output logic [FLAG_N-1:0]   w_any
);
   import ps_pkg::*;
   win_act_t act;

   always_comb begin
      act = strobe ? classify(win, in_win) : ACT_IDLE;
   end

   assign close_evt = (act == ACT_CLOSE);

   always_ff @(posedge clk) begin
      if (rst) begin
         in_win  <= 1'b0;
         pk_amp  <= '0;
         pk_time <= '0;
         t_start <= '0;
         w_peak  <= '0;
         w_any   <= '0;
      end else begin
         case (act)
            ACT_OPEN: begin
               in_win  <= 1'b1;
               pk_amp  <= sample;
               pk_time <= now_ts;
               t_start <= now_ts;
               w_peak  <= flags;
               w_any   <= flags;
            end
            ACT_HOLD: begin
               w_any <= w_any | flags;
               if (sample > pk_amp) begin
                  pk_amp  <= sample;
                  pk_time <= now_ts;
                  w_peak  <= flags;
               end
            end
            ACT_CLOSE: in_win <= 1'b0;
            default: ;
         endcase
      end
   end

   assert_peak_monotone_R4: assert property (@(posedge clk) disable iff (rst)
      (strobe && in_win && win) |=> (pk_amp >= $past(pk_amp)));
   assert_tie_keeps_R4: assert property (@(posedge clk) disable iff (rst)
      (strobe && in_win && win && (sample <= pk_amp)) |=> $stable(pk_time));
   assert_any_grows_R5: assert property (@(posedge clk) disable iff (rst)
      (strobe && in_win && win) |=> ((w_any & $past(w_any)) == $past(w_any)));
   assert_open_times_R3: assert property (@(posedge clk) disable iff (rst)
      (strobe && !in_win && win) |=> (in_win && (t_start == pk_time)));
   assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> ($stable(in_win) && $stable(pk_amp) && $stable(w_any)));
endmodule

// File: rtl/ps_result_emit.sv
module ps_result_emit #(
   parameter int SAMPLE_W = 16,
   parameter int FLAG_N   = 8,
   parameter int TS_W     = 32,
   parameter int CFG_W    = 16,
   parameter int DELAY    = 0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                close_evt,
   input  logic [SAMPLE_W-1:0] pk_amp,
   input  logic [TS_W-1:0]     pk_time,
   input  logic [TS_W-1:0]     t_start,
   input  logic [FLAG_N-1:0]   w_peak,
   input  logic [FLAG_N-1:0]   w_any,
   input  logic [TS_W-1:0]     now_ts,
   input  logic [CFG_W-1:0]    max_len,
   input  logic [CFG_W-1:0]    sat_ofs,
   output logic                out_valid,
   output logic [TS_W+SAMPLE_W+2*FLAG_N-1:0] out_data
);
   localparam int OUT_W = TS_W + SAMPLE_W + 2*FLAG_N;

   logic [TS_W-1:0] span;
   logic            saturated;
   logic [TS_W-1:0] rep_time;
   logic [DELAY:0]  vq;
   logic [OUT_W-1:0] dq [DELAY+1];

   always_comb begin
      span      = now_ts - t_start;
      saturated = span > TS_W'(max_len);
      rep_time  = saturated ? (t_start + TS_W'(sat_ofs)) : pk_time;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vq[0] <= 1'b0;
         dq[0] <= '0;
      end else begin
         vq[0] <= close_evt;
         if (close_evt) dq[0] <= {rep_time, pk_amp, w_peak, w_any};
      end
   end

   generate
      if (DELAY > 0) begin : g_delay
         for (genvar k = 1; k <= DELAY; k++) begin : g_stage
            always_ff @(posedge clk) begin
               if (rst) begin
                  vq[k] <= 1'b0;
                  dq[k] <= '0;
               end else begin
                  vq[k] <= vq[k-1];
                  dq[k] <= dq[k-1];
               end
            end
         end
      end
   endgenerate

   assign out_valid = vq[DELAY];
   assign out_data  = dq[DELAY];

   assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);
   assert_short_time_R7: assert property (@(posedge clk) disable iff (rst)
      (close_evt && ((now_ts - t_start) <= TS_W'(max_len)))
      |=> (dq[0][OUT_W-1 -: TS_W] == $past(pk_time)));
endmodule

// File: rtl/peak_prim_builder.sv
module peak_prim_builder #(
   parameter int SAMPLE_W = 16,
   parameter int FLAG_N   = 8,
   parameter int SEL_W    = 2,
   parameter int TS_W     = 32,
   parameter int CFG_W    = 16,
   parameter int INDEX    = 0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cfg_we,
   input  logic [CFG_W-1:0]         cfg_max_len,
   input  logic [CFG_W-1:0]         cfg_sat_ofs,
   input  logic [FLAG_N*SEL_W-1:0]  sel_map,
   input  logic                     pkt_strobe,
   input  logic [SAMPLE_W-1:0]      pkt_sample,
   input  logic [FLAG_N-1:0]        pkt_flags,
   input  logic [TS_W-1:0]          now_ts,
   output logic                     prim_valid,
   output logic [SEL_W-1:0]         prim_chan,
   output logic [TS_W+SAMPLE_W+2*FLAG_N-1:0] prim_data
);
   localparam int OUT_W = TS_W + SAMPLE_W + 2*FLAG_N;

   generate
      if (INDEX < 0 || INDEX >= (1 << SEL_W)) begin : g_bad_index
         $error("INDEX does not fit the selector width");
      end
      if (CFG_W > TS_W) begin : g_bad_cfg
         $error("configuration width exceeds timestamp width");
      end
   endgenerate

   logic [CFG_W-1:0]    max_len_q, sat_ofs_q;
   logic                win, in_win, close_evt;
   logic [SAMPLE_W-1:0] pk_amp;
   logic [TS_W-1:0]     pk_time, t_start;
   logic [FLAG_N-1:0]   w_peak, w_any;
   logic [OUT_W-1:0]    data_w;

   always_ff @(posedge clk) begin
      if (rst) begin
         max_len_q <= '0;
         sat_ofs_q <= '0;
      end else if (cfg_we) begin
         max_len_q <= cfg_max_len;
         sat_ofs_q <= cfg_sat_ofs;
      end
   end

   ps_window_gate #(.FLAG_N(FLAG_N), .SEL_W(SEL_W), .INDEX(INDEX)) u_gate (
      .flags(pkt_flags), .sel_map(sel_map), .win(win));

   ps_peak_tracker #(.SAMPLE_W(SAMPLE_W), .FLAG_N(FLAG_N), .TS_W(TS_W)) u_track (
      .clk(clk), .rst(rst), .strobe(pkt_strobe), .win(win),
      .sample(pkt_sample), .flags(pkt_flags), .now_ts(now_ts),
      .in_win(in_win), .close_evt(close_evt), .pk_amp(pk_amp),
      .pk_time(pk_time), .t_start(t_start), .w_peak(w_peak), .w_any(w_any));

   ps_result_emit #(.SAMPLE_W(SAMPLE_W), .FLAG_N(FLAG_N), .TS_W(TS_W),
                    .CFG_W(CFG_W), .DELAY(INDEX)) u_emit (
      .clk(clk), .rst(rst), .close_evt(close_evt), .pk_amp(pk_amp),
      .pk_time(pk_time), .t_start(t_start), .w_peak(w_peak), .w_any(w_any),
      .now_ts(now_ts), .max_len(max_len_q), .sat_ofs(sat_ofs_q),
      .out_valid(prim_valid), .out_data(data_w));

   assign prim_data = data_w;
   assign prim_chan = SEL_W'(INDEX);

   assert_reset_quiet_R9: assert property (@(posedge clk)
      rst |=> !prim_valid);
endmodule

// File: tb/tb_peak_prim_builder.sv
`timescale 1ns/100ps
module tb_peak_prim_builder;
   localparam int IDX = 2;

   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_we;
   logic [15:0] cfg_max_len, cfg_sat_ofs, sel_map;
   logic        pkt_strobe;
   logic [15:0] pkt_sample;
   logic [7:0]  pkt_flags;
   logic [31:0] now_ts;
   logic        prim_valid;
   logic [1:0]  prim_chan;
   logic [63:0] prim_data;

   int  total = 0, bad = 0;
   bit  done = 1'b0;

   logic        m_in;
   logic [15:0] m_amp;
   logic [31:0] m_pt, m_t0;
   logic [7:0]  m_wp, m_wa;
   logic [15:0] m_max, m_ofs;

   always #2.5 clk = ~clk;

   peak_prim_builder #(.INDEX(IDX)) dut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_max_len(cfg_max_len),
      .cfg_sat_ofs(cfg_sat_ofs), .sel_map(sel_map), .pkt_strobe(pkt_strobe),
      .pkt_sample(pkt_sample), .pkt_flags(pkt_flags), .now_ts(now_ts),
      .prim_valid(prim_valid), .prim_chan(prim_chan), .prim_data(prim_data));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [15:0] mx, input logic [15:0] of);
      cfg_max_len = mx; cfg_sat_ofs = of; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      m_max = mx; m_ofs = of;
   endtask

   task automatic pkt(input logic [15:0] s, input logic [7:0] f, input logic [31:0] t, input string tag);
      bit w = 1'b0;
      bit emit = 1'b0;
      logic [63:0] expd = '0;
      int first = -1;
      int n = 0;
      logic [63:0] got = '0;
      for (int i = 0; i < 8; i++)
         if (f[i] && (sel_map[2*i +: 2] == 2'(IDX))) w = 1'b1;
      if (!m_in && w) begin
         m_in = 1'b1; m_amp = s; m_pt = t; m_t0 = t; m_wp = f; m_wa = f;
      end else if (m_in && w) begin
         m_wa = m_wa | f;
         if (s > m_amp) begin m_amp = s; m_pt = t; m_wp = f; end
      end else if (m_in && !w) begin
         m_in = 1'b0; emit = 1'b1;
         expd = {((t - m_t0) > {16'd0, m_max}) ? m_t0 + {16'd0, m_ofs} : m_pt, m_amp, m_wp, m_wa};
      end
      pkt_sample = s; pkt_flags = f; now_ts = t; pkt_strobe = 1'b1;
      @(negedge clk);
      pkt_strobe = 1'b0;
      for (int j = 0; j < 6; j++) begin
         if (prim_valid) begin
            if (first < 0) first = j;
            n++;
            got = prim_data;
         end
         @(negedge clk);
      end
      if (emit) begin
         chk(first == IDX && n == 1, "R8 delay/pulse", 64'(first*16 + n), 64'(IDX*16 + 1));
         chk(got == expd, tag, got, expd);
         chk(prim_chan == 2'(IDX), "R8 chan", 64'(prim_chan), 64'(IDX));
      end else begin
         chk(n == 0, tag, 64'(n), 64'd0);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [31:0] t;
      rst = 1'b1; cfg_we = 1'b0; cfg_max_len = '0; cfg_sat_ofs = '0;
      sel_map = '0; pkt_strobe = 1'b0; pkt_sample = '0; pkt_flags = '0; now_ts = '0;
      m_in = 0; m_amp = 0; m_pt = 0; m_t0 = 0; m_wp = 0; m_wa = 0; m_max = 0; m_ofs = 0;
      repeat (4) @(negedge clk);
      chk(prim_valid == 1'b0, "R9 valid in reset", 64'(prim_valid), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(prim_valid == 1'b0, "R9 valid after reset", 64'(prim_valid), 64'd0);
      chk(prim_chan == 2'(IDX), "R8 chan after reset", 64'(prim_chan), 64'(IDX));

      // R9: zero limit and offset after reset -> saturated report of t0
      sel_map = {8{2'(IDX)}};
      pkt(16'd5, 8'h01, 32'd100, "R9 open");
      pkt(16'd9, 8'h01, 32'd101, "R9 hold");
      pkt(16'd1, 8'h00, 32'd102, "R9 zero cfg");

      // R10: loaded limit makes the same shape a normal pulse
      set_cfg(16'd1000, 16'd7);
      pkt(16'd5, 8'h01, 32'd200, "R10 open");
      pkt(16'd9, 8'h01, 32'd201, "R10 hold");
      pkt(16'd1, 8'h00, 32'd202, "R10 normal after load");

      // R1: sweep every flag against every selector value
      for (int i = 0; i < 8; i++)
         for (int v = 0; v < 4; v++) begin
            sel_map = {8{2'((IDX + 1) % 4)}};
            sel_map[2*i +: 2] = 2'(v);
            pkt(16'h0100 + 16'(i), 8'(1 << i), 32'd300 + 32'(i*8 + v), "R1 gate");
            pkt(16'h0000, 8'h00, 32'd301 + 32'(i*8 + v), "R1 gate close");
         end

      // R3 R4 R5 R6: flags 0 and 3 open the window, other flags only record
      sel_map = {8{2'((IDX + 1) % 4)}};
      sel_map[1:0] = 2'(IDX); sel_map[7:6] = 2'(IDX);
      pkt(16'd10,  8'h09, 32'd1000, "R3 open");
      pkt(16'd40,  8'h11, 32'd1001, "R4 rise");
      pkt(16'd40,  8'h29, 32'd1002, "R4 tie keeps earlier");
      pkt(16'd30,  8'h41, 32'd1003, "R5 or in");
      pkt(16'hFFF0, 8'h80, 32'd1004, "R5 close contributes nothing");
      pkt(16'hFFFF, 8'h08, 32'd1010, "R4 unsigned open");
      pkt(16'h7FFF, 8'h08, 32'd1011, "R4 unsigned smaller");
      pkt(16'd0,   8'h00, 32'd1012, "R6 layout");

      // R2: input changes without a strobe are ignored
      pkt(16'd20, 8'h01, 32'd1100, "R2 open");
      pkt_sample = 16'hFFFF; pkt_flags = 8'hFF; now_ts = 32'd5;
      repeat (3) @(negedge clk);
      chk(prim_valid == 1'b0, "R2 no output between strobes", 64'(prim_valid), 64'd0);
      pkt_flags = 8'h00;
      repeat (2) @(negedge clk);
      chk(prim_valid == 1'b0, "R2 window not closed without strobe", 64'(prim_valid), 64'd0);
      pkt(16'd0, 8'h00, 32'd1101, "R2 ignored data");

      // R7: boundary and rollover
      set_cfg(16'd10, 16'd3);
      pkt(16'd50, 8'h01, 32'd2000, "R7 open eq");
      pkt(16'd60, 8'h01, 32'd2004, "R7 hold eq");
      pkt(16'd0,  8'h00, 32'd2010, "R7 diff equals limit");
      pkt(16'd50, 8'h01, 32'd3000, "R7 open gt");
      pkt(16'd60, 8'h01, 32'd3004, "R7 hold gt");
      pkt(16'd0,  8'h00, 32'd3011, "R7 diff above limit");
      pkt(16'd50, 8'h01, 32'hFFFF_FFFC, "R7 open wrap");
      pkt(16'd0,  8'h00, 32'd5, "R7 wrap normal");
      pkt(16'd50, 8'h01, 32'hFFFF_FFFA, "R7 open wrap sat");
      pkt(16'd70, 8'h01, 32'hFFFF_FFFE, "R7 hold wrap sat");
      pkt(16'd0,  8'h00, 32'd5, "R7 wrap saturated");

      // mixed pseudo-random sequence
      set_cfg(16'd9, 16'd21);
      r = 32'h1234_5678; t = 32'd50000;
      for (int k = 0; k < 400; k++) begin
         r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
         t = t + 32'd1 + 32'(r[2:0]);
         pkt(r[31:16] & 16'h00FF, r[15:8] & 8'hC9, t, "R6 sequence");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule